// File: doc/BRIEF.md
# Windowed Write-Once Watchdog Timer

This block is a watchdog peripheral on a simple word-wide register port. A 12-bit down-counter steps once every 128 pulses of a slow-clock enable (256 steps per second from a 32.768 kHz source, so the longest timeout is 16 s). When the counter is at zero and another step arrives, the watchdog expires. It sets a sticky status flag, reloads the counter and, if enabled, pulses a reset request for one clock. Out of reset it already runs with the longest timeout and the reset request enabled.

Software sets the block up through a mode register that takes exactly one write after reset. The mode register holds the reload value, a restart window limit, a reset-enable bit, a debug-freeze bit and a switch-off bit. Software keeps the system alive by writing a keyed restart command to the control register. A restart is accepted only while the counter is at or below the window limit. A restart that comes too early is refused and recorded in a sticky error flag. Reading the status register returns both flags and the live count, and the read clears the flags.

Top module: `wdog_window`

## Requirements
- R1: After reset the mode word (address 1) reads 0x0FFF_1FFF: reload [11:0]=0xFFF, reset-enable bit 12=1, debug-freeze bit 13=0, switch-off bit 14=0, window [27:16]=0xFFF. The status word (address 2) reads count [27:16]=0xFFF, with the error flag (bit 1) and the expiry flag (bit 0) both clear.
- R2: The counter decrements by one for every PRESCALE (128) cycles in which `slck_en` is high while the watchdog runs.
- R3: A step taken while the count is zero is an expiry. An expiry sets status bit 0 and reloads the count from the reload field.
- R4: An expiry drives `rst_req` high for exactly one cycle, in the cycle after the expiry, when reset-enable is 1. When reset-enable is 0, `rst_req` stays low.
- R5: The first write to the mode register after reset takes effect and loads the counter with the new reload value. Every later mode write is ignored.
- R6: A control write (address 0) restarts the watchdog only when bits [31:24] equal 0xA5 and bit 0 is 1. Any other control write has no effect.
- R7: An accepted restart while count <= window reloads the counter from the reload field. A restart with count equal to the window is accepted. A restart and a step in the same cycle resolve to the reload.
- R8: An accepted restart while count > window leaves the counter alone and sets status bit 1.
- R9: Status bits 0 and 1 stay set until a status read, and the read clears them. A flag event in the same cycle as the read wins.
- R10: While switch-off is 1, the counter and prescaler hold, no expiry occurs and restart commands are ignored (no reload, no error flag).
- R11: While debug-freeze is 1 and `dbg_in` is high, the counter and the prescaler hold. When debug-freeze is 0, `dbg_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slck_en | input | 1 | One-cycle enable per slow-clock period |
| dbg_in | input | 1 | Debugger halt indication |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (status read clears the flags) |
| addr | input | 2 | Word address: 0 control, 1 mode, 2 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address (combinational) |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
A wrong count shows up in the status word at the next read. If that wrong count reaches zero, it also shows on `rst_req`, as an early, late or missing pulse (within one prescaler period when the step logic is wrong). A corrupted mode register shows in the mode read-back immediately, and through a changed timeout within one reload period. The bench compares every status read and every cycle of `rst_req` against its own cycle model, so a wrong flag or count is caught at the first read after it goes wrong.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W  = 12;
  localparam int WORD_W = 32;
  localparam logic [7:0] RESTART_KEY = 8'hA5;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t window;
    logic off;
    logic dbg_halt;
    logic rst_en;
    cnt_t reload;
  } mode_t;

  localparam mode_t MODE_RESET = '{window: {CNT_W{1'b1}}, off: 1'b0,
                                   dbg_halt: 1'b0, rst_en: 1'b1,
                                   reload: {CNT_W{1'b1}}};

  // Word layout: [11:0] reload, 12 rst_en, 13 dbg_halt, 14 off, [27:16] window
  function automatic mode_t mode_decode(input logic [WORD_W-1:0] w);
    mode_t m;
    logic unused_bits;
    unused_bits = ^{w[31:28], w[15]};
    m.reload   = w[11:0];
    m.rst_en   = w[12];
    m.dbg_halt = w[13];
    m.off      = w[14];
    m.window   = w[27:16];
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] mode_encode(input mode_t m);
    return {4'b0, m.window, 1'b0, m.off, m.dbg_halt, m.rst_en, m.reload};
  endfunction

  function automatic logic [WORD_W-1:0] status_encode(input cnt_t c,
                                                      input logic err,
                                                      input logic exp_f);
    return {4'b0, c, 14'b0, err, exp_f};
  endfunction

  function automatic logic restart_cmd(input logic [WORD_W-1:0] w);
    logic unused_bits;
    unused_bits = ^w[23:1];
    return (w[31:24] == RESTART_KEY) && w[0];
  endfunction

  function automatic logic in_window(input cnt_t c, input cnt_t win);
    return c <= win;
  endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slck_en,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;
  logic          step_en;

  assign step_en = slck_en && run;
  assign tick    = step_en && (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (step_en) begin
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R11
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(phase));
endmodule

// File: rtl/wdog_mode_reg.sv
module wdog_mode_reg
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output mode_t             mode,
  output logic              take,
  output logic              locked
);
  assign take = wr && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= MODE_RESET;
      locked <= 1'b0;
    end else if (take) begin
      mode   <= mode_decode(wdata);
      locked <= 1'b1;
    end
  end

  // R5
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(mode) && locked);
endmodule

// File: rtl/wdog_down_cnt.sv
module wdog_down_cnt #(
  parameter int W = 12,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         expire
);
  assign expire = tick && !load && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= RST_VAL;
    end else if (load) begin
      count <= load_val;
    end else if (expire) begin
      count <= reload;
    end else if (tick) begin
      count <= count - 1'b1;
    end
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expire) |=> (count == $past(count)) || (count == $past(count) - 1'b1));

  // R3
  exp_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count == $past(reload));
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_exp,
  input  logic set_err,
  input  logic clr,
  output logic exp_flag,
  output logic err_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_flag <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      exp_flag <= set_exp || (exp_flag && !clr);
      err_flag <= set_err || (err_flag && !clr);
    end
  end

  // R8
  win_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_err |=> err_flag);

  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_exp && !set_err) |=> !exp_flag && !err_flag);
endmodule

// File: rtl/wdog_window.sv
module wdog_window
  import wdog_pkg::*;
#(
  parameter int PRESCALE = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slck_en,
  input  logic              dbg_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rst_req
);
  mode_t mode;
  logic  mode_take, mode_locked;
  logic  run, freeze, tick_w;
  logic  restart_hit, restart_ok, restart_bad;
  logic  load, expire_w;
  cnt_t  load_val, count;
  logic  exp_flag, err_flag, stat_clr;

  assign freeze      = mode.dbg_halt && dbg_in;
  assign run         = !mode.off && !freeze;
  assign restart_hit = wr_en && (addr == A_CTRL) && restart_cmd(wdata) && !mode.off;
  assign restart_ok  = restart_hit && in_window(count, mode.window);
  assign restart_bad = restart_hit && !in_window(count, mode.window);
  assign load        = mode_take || restart_ok;
  assign load_val    = mode_take ? wdata[CNT_W-1:0] : mode.reload;
  assign stat_clr    = rd_en && (addr == A_STAT);

  wdog_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr_en && (addr == A_MODE)),
    .wdata  (wdata),
    .mode   (mode),
    .take   (mode_take),
    .locked (mode_locked)
  );

  wdog_prescale #(.DIV(PRESCALE)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .slck_en (slck_en),
    .run     (run),
    .tick    (tick_w)
  );

  wdog_down_cnt #(.W(CNT_W), .RST_VAL(MODE_RESET.reload)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_w),
    .load     (load),
    .load_val (load_val),
    .reload   (mode.reload),
    .count    (count),
    .expire   (expire_w)
  );

  wdog_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_exp  (expire_w),
    .set_err  (restart_bad),
    .clr      (stat_clr),
    .exp_flag (exp_flag),
    .err_flag (err_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= expire_w && mode.rst_en;
  end

  always_comb begin
    case (addr)
      A_MODE:  rdata = mode_encode(mode);
      A_STAT:  rdata = status_encode(count, err_flag, exp_flag);
      default: rdata = '0;
    endcase
  end

  logic unused_lock;
  assign unused_lock = mode_locked;

  // R4
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R4
  rst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && !mode.rst_en) |=> !rst_req);

  // R10
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.off && !mode_take) |=> !rst_req && $stable(count));

  // R11
  frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !load) |=> $stable(count));

  // R7
  win_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_ok && !mode_take) |=> count == $past(mode.reload));
endmodule

// File: tb/wdog_window_test.sv
`timescale 1ns/1ps
module wdog_window_test;
  localparam int PRE = 128;

  logic        clk = 0, rst_n = 0, slck_en = 0, dbg_in = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        rst_req;

  wdog_window #(.PRESCALE(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .slck_en(slck_en), .dbg_in(dbg_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rst_req(rst_req)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, pulses = 0;
  bit done = 0;

  // reference model state
  logic        m_locked, m_rsten, m_halt, m_off, m_uf, m_err, m_rst;
  logic [11:0] m_reload, m_win, m_cnt;
  int          m_pre;

  function automatic logic [31:0] mword();
    logic [31:0] w = '0;
    w[27:16] = m_win; w[14] = m_off; w[13] = m_halt; w[12] = m_rsten; w[11:0] = m_reload;
    return w;
  endfunction

  function automatic logic [31:0] sword();
    logic [31:0] w = '0;
    w[27:16] = m_cnt; w[1] = m_err; w[0] = m_uf;
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_locked = 0; m_rsten = 1; m_halt = 0; m_off = 0; m_reload = 12'hFFF;
      m_win = 12'hFFF; m_cnt = 12'hFFF; m_pre = 0; m_uf = 0; m_err = 0; m_rst = 0;
    end else begin
      bit tk, mw, hit, good, ld, ex, clr;
      logic [11:0] ldv;
      tk = 0;
      if (slck_en && !m_off && !(m_halt && dbg_in)) begin
        m_pre = m_pre + 1;
        if (m_pre == PRE) begin tk = 1; m_pre = 0; end
      end
      mw   = wr_en && addr == 2'd1 && !m_locked;
      hit  = wr_en && addr == 2'd0 && wdata[31:24] == 8'hA5 && wdata[0] && !m_off;
      good = hit && (m_cnt <= m_win);
      ld   = mw || good;
      ldv  = mw ? wdata[11:0] : m_reload;
      ex   = tk && !ld && m_cnt == 0;
      clr  = rd_en && addr == 2'd2;
      m_rst = ex && m_rsten;
      m_uf  = ex || (m_uf && !clr);
      m_err = (hit && !good) || (m_err && !clr);
      if (ld) m_cnt = ldv;
      else if (ex) m_cnt = m_reload;
      else if (tk) m_cnt = m_cnt - 1;
      if (mw) begin
        m_locked = 1; m_reload = wdata[11:0]; m_rsten = wdata[12];
        m_halt = wdata[13]; m_off = wdata[14]; m_win = wdata[27:16];
      end
    end
  end

  // R4: reset request compared with the model every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rst_req !== m_rst) begin
        checks++; fails++;
        $display("FAIL R4 rst_req got %b exp %b at %0t", rst_req, m_rst, $time);
      end else if (m_rst) begin
        checks++; pulses++;
      end
    end
  end

  initial begin
    void'($urandom(32'd41));
    forever begin
      @(negedge clk);
      slck_en = ($urandom_range(3) != 0);
    end
  end

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; rd_en = 0; dbg_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input string tag);
    logic [31:0] e;
    addr = a; rd_en = 1;
    #1;
    e = (a == 2'd1) ? mword() : (a == 2'd2) ? sword() : 32'h0;
    chk(rdata, e, tag);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wait_cnt(input logic [11:0] v);
    while (m_cnt != v) @(negedge clk);
  endtask

  initial begin
    int p0;
    void'($urandom(32'd97));
    do_reset();
    // R1 reset state
    addr = 2'd1; #1; chk(rdata, 32'h0FFF_1FFF, "R1 mode reset");
    addr = 2'd2; #1; chk(rdata, 32'h0FFF_0000, "R1 status reset");
    @(negedge clk);
    repeat (600) @(negedge clk);
    rd_chk(2'd2, "R2 count after prescaled steps");

    // R5 first write, R3/R4 expiry with pulse
    wr(2'd1, 32'h0FFF_1005);
    rd_chk(2'd1, "R5 first mode write");
    rd_chk(2'd2, "R5 counter loaded");
    p0 = pulses;
    while (!m_uf) @(negedge clk);
    @(negedge clk);
    chk(pulses - p0, 1, "R4 one pulse on expiry");
    rd_chk(2'd2, "R3 expiry flag and reload");
    rd_chk(2'd2, "R9 flags cleared by read");
    wr(2'd1, 32'h0001_4FFF);
    rd_chk(2'd1, "R5 second mode write ignored");

    // R6 bad key / missing bit
    wait_cnt(12'd2);
    wr(2'd0, 32'h5A00_0001);
    wr(2'd0, 32'hA500_0000);
    rd_chk(2'd2, "R6 malformed control writes ignored");

    // R7 / R8 window
    do_reset();
    wr(2'd1, 32'h000A_1014);
    wr(2'd0, 32'hA500_0001);
    rd_chk(2'd2, "R8 early restart flagged");
    chk({31'b0, rdata[1]}, 32'h0, "R9 error cleared after read");
    wait_cnt(12'd11);
    wr(2'd0, 32'hA500_0001);
    rd_chk(2'd2, "R8 restart at window+1 refused");
    wait_cnt(12'd10);
    wr(2'd0, 32'hA500_0001);
    addr = 2'd2; #1;
    chk({20'b0, rdata[27:16]}, 32'd20, "R7 restart at window reloads");
    @(negedge clk);
    rd_chk(2'd2, "R7 status after good restart");

    // R4 reset-enable clear
    do_reset();
    wr(2'd1, 32'h0FFF_0003);
    p0 = pulses;
    while (!m_uf) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(pulses - p0, 0, "R4 no pulse with reset disabled");
    rd_chk(2'd2, "R3 expiry flag without pulse");

    // R10 switched off
    do_reset();
    wr(2'd1, 32'h0FFF_5005);
    repeat (3000) @(negedge clk);
    wr(2'd0, 32'hA500_0001);
    addr = 2'd2; #1;
    chk(rdata, 32'h0005_0000, "R10 switched off holds and ignores restart");
    @(negedge clk);

    // R11 debug freeze
    do_reset();
    wr(2'd1, 32'h0FFF_3008);
    dbg_in = 1;
    repeat (2000) @(negedge clk);
    addr = 2'd2; #1;
    chk(rdata, 32'h0008_0000, "R11 frozen under debug");
    @(negedge clk);
    dbg_in = 0;
    repeat (700) @(negedge clk);
    rd_chk(2'd2, "R11 counts after debug release");
    do_reset();
    wr(2'd1, 32'h0FFF_1008);
    dbg_in = 1;
    repeat (700) @(negedge clk);
    rd_chk(2'd2, "R11 debug ignored without freeze bit");
    dbg_in = 0;

    // random mix
    do_reset();
    wr(2'd1, 32'h0006_3010);
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(9);
      case (op)
        0: wr(2'd0, 32'hA500_0001);
        1: wr(2'd0, {$urandom_range(255) == 165 ? 8'h00 : 8'($urandom_range(255)), 24'h1});
        2: rd_chk(2'd2, "R9 random status read");
        3: begin dbg_in = ~dbg_in; @(negedge clk); end
        4: wr(2'd1, $urandom);
        default: @(negedge clk);
      endcase
    end
    rd_chk(2'd1, "R5 mode after random writes");
    rd_chk(2'd2, "R2 final status");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired got running exp finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule